// File: doc/BRIEF.md
# Configuration Store Access Controller

This block guards the configuration store of a programmable logic device. The store holds a pattern of logic-array words plus architecture settings, a 64-bit identification word, and a one-bit security latch. All of it is modelled here as registers. Commands come in on a single valid strobe. Each command carries an operation code, an address, a data word and a seal flag. A small sequencer keeps `busy` high for a fixed number of cycles per operation, and the store changes only on the last of those cycles.

Once the security latch is set, the controller refuses every access to the pattern and to the identification word. This covers read, program, identification write and identification read. A refused command changes nothing, returns zero data and raises a one-cycle error pulse. The latch can be set in two ways: by a program command that has its seal flag set, or by a separate seal command. The only way to clear it again is a full erase, which also returns the pattern and the identification word to zero. Reset models a blank part in the same way: everything is erased and unlocked.

Top module: `cfgsec_ctrl`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `err` are low, every pattern and identification word reads as zero, and the latch is clear.
- R2: A command is accepted at a rising edge where `cmd_valid` is high and `busy` is low. From the next cycle, `busy` stays high for PROG_CYC cycles for program (code 1) and identification write (code 4), for ERASE_CYC cycles for erase (code 0), and for 1 cycle for every other command, including refused ones.
- R3: Program (code 1) stores `cmd_wdata` into pattern word `cmd_addr`. Read (code 2) returns that word on `rd_data`, with `rd_valid` high during the single cycle after the accepting edge.
- R4: The 64-bit identification word is split into 64/DATA_W slices. Identification write (code 4) stores `cmd_wdata` into the slice selected by the low bits of `cmd_addr`, and identification read (code 5) returns that slice in the same way as R3.
- R5: Seal (code 3) sets the latch. A program command with `cmd_seal` high writes its word and then sets the latch.
- R6: While the latch is set, codes 1, 2, 4 and 5 are refused. A refused command leaves the store unchanged and pulses `err`. If it is a read kind (code 2 or 5), `rd_valid` also pulses and `rd_data` is zero.
- R7: Erase (code 0) is always accepted. It clears all pattern words and all identification slices to zero and clears the latch, which restores normal access.
- R8: A `cmd_valid` raised while `busy` is high is ignored: the store does not change and the command in progress keeps its timing.
- R9: Codes 6 and 7 are refused whether or not the latch is set. They pulse `err`, do not raise `rd_valid`, and take 1 busy cycle.
- R10: `err` and `rd_valid` are never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | ADDR_W | Pattern word address, or identification slice index in its low bits |
| cmd_wdata | input | DATA_W | Write data |
| cmd_seal | input | 1 | Set the latch after this program command completes |
| busy | output | 1 | Command in progress |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | DATA_W | Read result, zero when refused |
| err | output | 1 | Command refused |

## Verification
The bench uses the default parameters: ADDR_W=4, DATA_W=16, PROG_CYC=4 and ERASE_CYC=16. A 16-word pattern lets random addresses hit rewritten words often. The identification word splits into four slices, so slice selection from the low address bits is checked at both of its ends. Because the 16-cycle erase is much longer than the 4-cycle program, a wrong cycle count shows up clearly. Randomly placed seal and erase commands drive the latch through many lock and unlock sequences, each followed by refused accesses whose data must read as zero.

// File: rtl/cfgsec_pkg.sv
// Shared operation codes for the configuration store access controller.
// Assumes a 3-bit operation field; codes 6 and 7 are undefined.
package cfgsec_pkg;
    typedef enum logic [2:0] {
        OP_ERASE = 3'd0,
        OP_PROG  = 3'd1,
        OP_READ  = 3'd2,
        OP_SEAL  = 3'd3,
        OP_SIGWR = 3'd4,
        OP_SIGRD = 3'd5
    } op_e;
endpackage

// File: rtl/cfgsec_guard.sv
// Access policy: decides whether an operation is allowed under the current
// latch state, whether it returns data, and how many busy cycles it takes.
// Assumes ERASE_CYC >= PROG_CYC >= 1.
module cfgsec_guard
    import cfgsec_pkg::*;
#(
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 16,
    localparam int CNT_W    = $clog2(ERASE_CYC + 1)
) (
    input  logic [2:0]       op,
    input  logic             locked,
    output logic             permit,
    output logic             is_read,
    output logic [CNT_W-1:0] cycles
);
    // Classify the operation against the latch.
    always_comb begin
        permit  = 1'b0;
        is_read = 1'b0;
        cycles  = CNT_W'(1);
        case (op)
            OP_ERASE: begin
                permit = 1'b1;
                cycles = CNT_W'(ERASE_CYC);
            end
            OP_SEAL:  permit = 1'b1;
            OP_PROG, OP_SIGWR: begin
                permit = !locked;
                cycles = locked ? CNT_W'(1) : CNT_W'(PROG_CYC);
            end
            OP_READ, OP_SIGRD: begin
                permit  = !locked;
                is_read = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfgsec_seq.sv
// Command sequencer: accepts one command when idle, latches it, counts the
// busy window and emits a one-cycle commit on its last cycle when allowed.
// Assumes cycles >= 1 at acceptance.
module cfgsec_seq #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    parameter int ERASE_CYC = 16,
    localparam int CNT_W    = $clog2(ERASE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_seal,
    input  logic              permit,
    input  logic [CNT_W-1:0]  cycles,
    output logic              busy,
    output logic              accept,
    output logic              commit,
    output logic [2:0]        op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              seal_q
);
    logic [CNT_W-1:0] cnt;
    logic             ok_q;

    assign accept = cmd_valid && !busy;
    assign commit = busy && (cnt == '0) && ok_q;

    // Latch the accepted command and run the busy countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            ok_q   <= 1'b0;
            op_q   <= '0;
            addr_q <= '0;
            data_q <= '0;
            seal_q <= 1'b0;
        end else if (accept) begin
            busy   <= 1'b1;
            cnt    <= cycles - CNT_W'(1);
            ok_q   <= permit;
            op_q   <= cmd_op;
            addr_q <= cmd_addr;
            data_q <= cmd_wdata;
            seal_q <= cmd_seal;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - CNT_W'(1);
        end
    end

    // R8
    // busy_hold_chk: mid-command, nothing new is latched
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (cnt != '0) |=> busy && $stable(op_q) && $stable(addr_q)
                                && $stable(data_q));

    // R2
    // cnt_range_chk: countdown never exceeds the longest command
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt < CNT_W'(ERASE_CYC)));
endmodule

// File: rtl/cfgsec_store.sv
// Register model of the configuration store: pattern words, identification
// slices and the security latch. It changes only on a commit strobe and
// reads combinationally. Reset models a blank, unlocked part.
module cfgsec_store
    import cfgsec_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    parameter int SIG_BITS  = 64,
    localparam int PAT_WORDS = 1 << ADDR_W,
    localparam int SIG_WORDS = SIG_BITS / DATA_W,
    localparam int SIG_AW    = (SIG_WORDS > 1) ? $clog2(SIG_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [2:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              seal,
    input  logic [2:0]        rd_op,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic              locked
);
    logic [DATA_W-1:0] pat [PAT_WORDS];
    logic [DATA_W-1:0] sig [SIG_WORDS];
    logic              wipe;

    assign wipe = commit && (op == OP_ERASE);

    for (genvar w = 0; w < PAT_WORDS; w++) begin : g_pat
        // One pattern word: cleared by erase, loaded by its program.
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)
                pat[w] <= '0;
            else if (commit && op == OP_PROG && addr == ADDR_W'(w))
                pat[w] <= wdata;
        end
    end

    for (genvar s = 0; s < SIG_WORDS; s++) begin : g_sig
        // One identification slice: cleared by erase, loaded by its write.
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)
                sig[s] <= '0;
            else if (commit && op == OP_SIGWR && addr[SIG_AW-1:0] == SIG_AW'(s))
                sig[s] <= wdata;
        end
    end

    // Security latch: set by seal or sealed program, cleared only by erase.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)
            locked <= 1'b0;
        else if (commit && (op == OP_SEAL || (op == OP_PROG && seal)))
            locked <= 1'b1;
    end

    // Select the word a read command returns.
    always_comb begin
        if (rd_op == OP_SIGRD) rd_word = sig[rd_addr[SIG_AW-1:0]];
        else                   rd_word = pat[rd_addr];
    end

    // R7
    // lock_clear_chk: the latch drops only through an erase commit
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) && $past(rst_n) |-> $past(commit && op == OP_ERASE));

    // R6
    // locked_nowrite_chk: no content commit is possible while locked
    locked_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && locked |-> (op == OP_ERASE || op == OP_SEAL));
endmodule

// File: rtl/cfgsec_ctrl.sv
// Top of the configuration store access controller. Connects the policy,
// the sequencer and the store, and registers the read result and error
// pulses on the accepting edge. Assumes one command in flight at a time.
module cfgsec_ctrl
    import cfgsec_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 16,
    parameter int SIG_BITS  = 64,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 16,
    localparam int CNT_W    = $clog2(ERASE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_seal,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              err
);
    logic              permit, is_read, accept, commit, locked, seal_q;
    logic [CNT_W-1:0]  cycles;
    logic [2:0]        op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q, rd_word;

    cfgsec_guard #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_guard (
        .op(cmd_op), .locked(locked), .permit(permit),
        .is_read(is_read), .cycles(cycles)
    );

    cfgsec_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CYC(ERASE_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_seal(cmd_seal),
        .permit(permit), .cycles(cycles), .busy(busy), .accept(accept),
        .commit(commit), .op_q(op_q), .addr_q(addr_q), .data_q(data_q),
        .seal_q(seal_q)
    );

    cfgsec_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_BITS(SIG_BITS)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .op(op_q), .addr(addr_q),
        .wdata(data_q), .seal(seal_q), .rd_op(cmd_op), .rd_addr(cmd_addr),
        .rd_word(rd_word), .locked(locked)
    );

    // Register the result and refusal pulses on the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            err      <= 1'b0;
        end else begin
            rd_valid <= accept && is_read;
            err      <= accept && !permit;
            if (accept && is_read) rd_data <= permit ? rd_word : '0;
        end
    end

    // R10
    // err_pulse_chk: a refusal pulse lasts one cycle
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R10
    // rdv_pulse_chk: a result strobe lasts one cycle
    rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R6
    // refused_zero_chk: refused reads return zero
    refused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && err |-> rd_data == '0);

    // R3
    // rdv_after_accept_chk: a result follows an accepting edge
    rdv_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(cmd_valid && !busy) && busy);
endmodule

// File: tb/tb_cfgsec_ctrl.sv
// Self-checking bench: random command mix plus directed corner cases,
// compared against a bench-side model of the store and latch.
module tb_cfgsec_ctrl;
    localparam int AW = 4, DW = 16, PC = 4, EC = 16, NSIG = 4;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          cmd_valid = 1'b0, cmd_seal = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          busy, rd_valid, err;
    logic [DW-1:0] rd_data;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    logic [DW-1:0] m_pat [1 << AW];
    logic [DW-1:0] m_sig [NSIG];
    bit            m_lock;

    cfgsec_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SIG_BITS(64),
                  .PROG_CYC(PC), .ERASE_CYC(EC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_seal(cmd_seal),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .err(err)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_permit(input logic [2:0] op);
        if (op == 3'd0 || op == 3'd3) return 1'b1;
        if (op <= 3'd5) return !m_lock;
        return 1'b0;
    endfunction

    function automatic int exp_cycles(input logic [2:0] op);
        if (!exp_permit(op)) return 1;
        if (op == 3'd0) return EC;
        if (op == 3'd1 || op == 3'd4) return PC;
        return 1;
    endfunction

    function automatic logic [DW-1:0] exp_read(input logic [2:0] op, input logic [AW-1:0] a);
        if (!exp_permit(op)) return '0;
        return (op == 3'd5) ? m_sig[a[1:0]] : m_pat[a];
    endfunction

    task automatic model_commit(input logic [2:0] op, input logic [AW-1:0] a,
                                input logic [DW-1:0] d, input bit s);
        if (!exp_permit(op)) return;
        case (op)
            3'd0: begin
                foreach (m_pat[i]) m_pat[i] = '0;
                foreach (m_sig[i]) m_sig[i] = '0;
                m_lock = 1'b0;
            end
            3'd1: begin m_pat[a] = d; if (s) m_lock = 1'b1; end
            3'd3: m_lock = 1'b1;
            3'd4: m_sig[a[1:0]] = d;
            default: ;
        endcase
    endtask

    // Issue one command; optionally poke a second one while busy (R8).
    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input bit s, input bit poke);
        bit            rk = (op == 3'd2 || op == 3'd5);
        logic [DW-1:0] er = exp_read(op, a);
        int            n = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_seal = s;
        @(negedge clk);
        cmd_valid = 1'b0;
        // R6 R9: refusal pulse
        check("R6/R9 err", err, !exp_permit(op));
        // R3 R4: result strobe one cycle after acceptance
        check("R3/R4 rd_valid", rd_valid, rk);
        if (rk) check("R3/R4/R6 rd_data", rd_data, er);
        while (busy && n < 100) begin
            n++;
            if (poke && n == 2) begin
                cmd_valid = 1'b1; cmd_op = 3'd1; cmd_addr = ~a; cmd_wdata = ~d;
                cmd_seal = 1'b1;
            end else cmd_valid = 1'b0;
            @(negedge clk);
            if (n == 1) check("R10 pulses", {30'd0, err, rd_valid}, 0);
        end
        cmd_valid = 1'b0;
        // R2: busy window length
        check("R2 busy cycles", n, exp_cycles(op));
        model_commit(op, a, d, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        foreach (m_pat[i]) m_pat[i] = '0;
        foreach (m_sig[i]) m_sig[i] = '0;
        m_lock = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 err", err, 0);
        rst_n = 1'b1;
        issue(3'd2, 4'd9, '0, 0, 0);          // R1: erased pattern reads zero
        issue(3'd5, 4'd3, '0, 0, 0);          // R1: erased slice reads zero
        // R3 R4 directed
        issue(3'd1, 4'd0, 16'hA55A, 0, 0);
        issue(3'd1, 4'd15, 16'h1234, 0, 0);
        issue(3'd2, 4'd15, '0, 0, 0);
        issue(3'd4, 4'd0, 16'hBEEF, 0, 0);
        issue(3'd4, 4'd7, 16'hCAFE, 0, 0);    // slice 3 via low bits
        issue(3'd5, 4'd3, '0, 0, 0);
        issue(3'd5, 4'd8, '0, 0, 0);          // slice 0
        // R8: poke during program, then read poked address
        issue(3'd1, 4'd2, 16'h0F0F, 0, 1);
        issue(3'd2, 4'd13, '0, 0, 0);
        issue(3'd2, 4'd2, '0, 0, 0);
        // R9: undefined codes
        issue(3'd6, 4'd1, 16'hFFFF, 0, 0);
        issue(3'd7, 4'd1, 16'hFFFF, 0, 0);
        // R5: sealed program, then refused accesses (R6)
        issue(3'd1, 4'd5, 16'h7777, 1, 0);
        issue(3'd2, 4'd5, '0, 0, 0);
        issue(3'd5, 4'd0, '0, 0, 0);
        issue(3'd1, 4'd5, 16'h1111, 0, 0);
        issue(3'd4, 4'd0, 16'h2222, 0, 0);
        // R7: erase restores access and clears contents
        issue(3'd0, 4'd0, '0, 0, 0);
        issue(3'd2, 4'd5, '0, 0, 0);
        issue(3'd5, 4'd0, '0, 0, 0);
        // R5: separate seal command
        issue(3'd1, 4'd6, 16'h6060, 0, 0);
        issue(3'd3, 4'd0, '0, 0, 0);
        issue(3'd2, 4'd6, '0, 0, 0);
        issue(3'd0, 4'd0, '0, 0, 0);
        // Random mix
        for (int k = 0; k < 300; k++) begin
            int unsigned r = $urandom % 100;
            logic [2:0] op;
            if      (r < 30) op = 3'd1;
            else if (r < 55) op = 3'd2;
            else if (r < 67) op = 3'd4;
            else if (r < 79) op = 3'd5;
            else if (r < 85) op = 3'd3;
            else if (r < 91) op = 3'd0;
            else             op = 3'(6 + ($urandom % 2));
            issue(op, AW'($urandom), DW'($urandom), ($urandom % 16) == 0,
                  ($urandom % 8) == 0);
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule